// File: doc/BRIEF.md
# Critical-Path Clock Calibration Controller

This controller tunes the frequency of a local clock generator. A timing monitor watches a critical path and reports whether it finished late or finished early by more than the slack margin. The controller turns each trusted report into a one-step change of an 8-bit frequency code. The code rises for a faster clock, falls for a slower one, or stays put. A report is trusted only in a cycle where the monitor flags that a worst-case operand vector is on the path. Reports from any other cycle say nothing about the true critical delay, so they are discarded.

A start request opens a calibration phase. During this phase the controller asks the datapath to inject the worst-case vector continuously. The phase ends once a set number of consecutive "no change" verdicts has been seen. At that point the lock flag rises, injection stops, and calibration carries on in situ whenever a natural worst-case vector appears. After every code change a hold output blocks datapath evaluation for a programmable number of cycles while the clock settles. The oscillator, the converter and the analog delay sensor are outside the block.

Top module: `clkcal_ctrl`

## Requirements
- R1: While reset is active, and for the cycles up to the first start request, freq_code equals INIT_CODE (default 128), and hold, locked and force_wc are all 0.
- R2: Before the first start request the block is idle: check results never change freq_code.
- R3: One cycle after cal_start is sampled high, force_wc is 1 and locked is 0. A check result sampled in the same cycle as cal_start is ignored.
- R4: An accepted result with chk_late=1 lowers freq_code by exactly 1 on the next cycle. chk_late takes priority over chk_early.
- R5: An accepted result with chk_late=0 and chk_early=1 raises freq_code by exactly 1 on the next cycle.
- R6: An accepted result with chk_late=0 and chk_early=0 is a stop verdict and leaves freq_code unchanged.
- R7: freq_code saturates at 0 and at 255 and never wraps. A step request at a limit changes nothing and starts no hold.
- R8: After each actual code change, hold is 1 for exactly settle_len cycles, starting in the cycle after the change. A settle_len of 0 gives no hold.
- R9: While hold is 1, check results are ignored.
- R10: Check results are ignored in any cycle with wc_seen=0.
- R11: During the calibration phase, LOCK_N (default 4) consecutive accepted stop verdicts set locked to 1 and force_wc to 0 on the next cycle. Any accepted up or down request, including one blocked at a limit, restarts the count.
- R12: After lock, accepted results keep stepping freq_code in situ and locked stays 1 until the next cal_start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cal_start | input | 1 | Request to begin a startup calibration phase |
| wc_seen | input | 1 | A worst-case vector is on the monitored path this cycle |
| chk_late | input | 1 | Monitored path completed after the sampling point |
| chk_early | input | 1 | Monitored path completed earlier than the slack margin |
| settle_len | input | SETTLE_W (4) | Hold cycles after each code change |
| freq_code | output | CODE_W (8) | Frequency control word to the clock generator |
| hold | output | 1 | Datapath evaluation must be blocked |
| force_wc | output | 1 | Datapath should inject the worst-case vector |
| locked | output | 1 | Startup calibration has converged |

## Verification
The assertions assume that settle_len changes only between code changes. They also assume that chk_late and chk_early carry meaning only alongside wc_seen, and that the bench may raise both at once to exercise the priority rule. The random stimulus draws settle_len from 0 to 3, gives wc_seen roughly even odds, and raises cal_start rarely so that lock can be reached. Directed runs push the code to both limits and interrupt a run of stop verdicts.

// File: rtl/clkcal_pkg.sv
package clkcal_pkg;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_START = 2'd1,
    PH_RUN   = 2'd2
  } phase_t;

  typedef enum logic [1:0] {
    V_NONE = 2'd0,
    V_STOP = 2'd1,
    V_UP   = 2'd2,
    V_DOWN = 2'd3
  } verdict_t;

endpackage

// File: rtl/clkcal_verdict.sv
module clkcal_verdict
  import clkcal_pkg::*;
(
  input  logic     active,
  input  logic     cal_start,
  input  logic     wc_seen,
  input  logic     hold,
  input  logic     chk_late,
  input  logic     chk_early,
  output verdict_t verdict
);

  logic accept;

  always_comb begin
    accept = active && wc_seen && !hold && !cal_start;
    if (!accept)        verdict = V_NONE;
    else if (chk_late)  verdict = V_DOWN;
    else if (chk_early) verdict = V_UP;
    else                verdict = V_STOP;
  end

endmodule

// File: rtl/clkcal_code.sv
module clkcal_code
  import clkcal_pkg::*;
#(
  parameter int CODE_W    = 8,
  parameter int INIT_CODE = 128
) (
  input  logic              clk,
  input  logic              rst_n,
  input  verdict_t          verdict,
  output logic [CODE_W-1:0] code,
  output logic              changed
);

  localparam logic [CODE_W-1:0] CODE_MAX  = {CODE_W{1'b1}};
  localparam logic [CODE_W-1:0] CODE_MIN  = '0;
  localparam logic [CODE_W-1:0] CODE_RST  = CODE_W'(INIT_CODE);
  localparam logic [CODE_W-1:0] CODE_ONE  = CODE_W'(1);

  logic [CODE_W-1:0] code_q, code_d;
  logic              code_en;

  always_comb begin
    code_d  = code_q;
    code_en = 1'b0;
    unique case (verdict)
      V_UP: begin
        if (code_q != CODE_MAX) begin
          code_d  = code_q + CODE_ONE;
          code_en = 1'b1;
        end
      end
      V_DOWN: begin
        if (code_q != CODE_MIN) begin
          code_d  = code_q - CODE_ONE;
          code_en = 1'b1;
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       code_q <= CODE_RST;
    else if (code_en) code_q <= code_d;
  end

  assign code    = code_q;
  assign changed = code_en;

  a_r4_down_step: assert property (@(posedge clk) disable iff (!rst_n)
    (verdict == V_DOWN && code_q != CODE_MIN) |=> (code_q == $past(code_q) - CODE_ONE));

  a_r5_up_step: assert property (@(posedge clk) disable iff (!rst_n)
    (verdict == V_UP && code_q != CODE_MAX) |=> (code_q == $past(code_q) + CODE_ONE));

  a_r6_stop_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (verdict == V_STOP || verdict == V_NONE) |=> $stable(code_q));

  a_r7_no_wrap_top: assert property (@(posedge clk) disable iff (!rst_n)
    (code_q == CODE_MAX) |=> (code_q == CODE_MAX || code_q == CODE_MAX - CODE_ONE));

  a_r7_no_wrap_bot: assert property (@(posedge clk) disable iff (!rst_n)
    (code_q == CODE_MIN) |=> (code_q == CODE_MIN || code_q == CODE_ONE));

endmodule

// File: rtl/clkcal_settle.sv
module clkcal_settle #(
  parameter int SETTLE_W = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                load,
  input  logic [SETTLE_W-1:0] settle_len,
  output logic                hold
);

  localparam logic [SETTLE_W-1:0] CNT_ONE = SETTLE_W'(1);

  logic [SETTLE_W-1:0] cnt_q, cnt_d;
  logic                cnt_en;

  always_comb begin
    cnt_d  = cnt_q;
    cnt_en = 1'b0;
    if (load) begin
      cnt_d  = settle_len;
      cnt_en = 1'b1;
    end else if (cnt_q != '0) begin
      cnt_d  = cnt_q - CNT_ONE;
      cnt_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign hold = (cnt_q != '0);

  a_r8_hold_starts: assert property (@(posedge clk) disable iff (!rst_n)
    (load && settle_len != '0) |=> hold);

  a_r8_zero_no_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (load && settle_len == '0) |=> !hold);

  a_r8_hold_drains: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && cnt_q == CNT_ONE) |=> !hold);

endmodule

// File: rtl/clkcal_seq.sv
module clkcal_seq
  import clkcal_pkg::*;
#(
  parameter int LOCK_N = 4
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     cal_start,
  input  verdict_t verdict,
  output phase_t   phase,
  output logic     locked
);

  localparam int            RUN_W    = $clog2(LOCK_N + 1);
  localparam logic [RUN_W-1:0] RUN_LAST = RUN_W'(LOCK_N - 1);
  localparam logic [RUN_W-1:0] RUN_ONE  = RUN_W'(1);

  phase_t           phase_q, phase_d;
  logic [RUN_W-1:0] run_q, run_d;
  logic             lock_q, lock_d;
  logic             seq_en;

  always_comb begin
    phase_d = phase_q;
    run_d   = run_q;
    lock_d  = lock_q;
    seq_en  = 1'b0;
    if (cal_start) begin
      phase_d = PH_START;
      run_d   = '0;
      lock_d  = 1'b0;
      seq_en  = 1'b1;
    end else if (phase_q == PH_START) begin
      unique case (verdict)
        V_STOP: begin
          seq_en = 1'b1;
          if (run_q == RUN_LAST) begin
            phase_d = PH_RUN;
            lock_d  = 1'b1;
            run_d   = '0;
          end else begin
            run_d = run_q + RUN_ONE;
          end
        end
        V_UP, V_DOWN: begin
          run_d  = '0;
          seq_en = 1'b1;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      run_q   <= '0;
      lock_q  <= 1'b0;
    end else if (seq_en) begin
      phase_q <= phase_d;
      run_q   <= run_d;
      lock_q  <= lock_d;
    end
  end

  assign phase  = phase_q;
  assign locked = lock_q;

  a_r3_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
    cal_start |=> (phase_q == PH_START && !lock_q));

  a_r11_lock_phase: assert property (@(posedge clk) disable iff (!rst_n)
    lock_q |-> (phase_q == PH_RUN));

  a_r12_lock_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_q && !cal_start) |=> lock_q);

endmodule

// File: rtl/clkcal_ctrl.sv
module clkcal_ctrl
  import clkcal_pkg::*;
#(
  parameter int CODE_W    = 8,
  parameter int INIT_CODE = 128,
  parameter int SETTLE_W  = 4,
  parameter int LOCK_N    = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cal_start,
  input  logic                wc_seen,
  input  logic                chk_late,
  input  logic                chk_early,
  input  logic [SETTLE_W-1:0] settle_len,
  output logic [CODE_W-1:0]   freq_code,
  output logic                hold,
  output logic                force_wc,
  output logic                locked
);

  // reset synchronizer: asserts at once, releases on the clock
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  phase_t   phase;
  verdict_t verdict;
  logic     code_chg;

  clkcal_verdict u_verdict (
    .active    (phase != PH_IDLE),
    .cal_start (cal_start),
    .wc_seen   (wc_seen),
    .hold      (hold),
    .chk_late  (chk_late),
    .chk_early (chk_early),
    .verdict   (verdict)
  );

  clkcal_code #(
    .CODE_W    (CODE_W),
    .INIT_CODE (INIT_CODE)
  ) u_code (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .verdict (verdict),
    .code    (freq_code),
    .changed (code_chg)
  );

  clkcal_settle #(
    .SETTLE_W (SETTLE_W)
  ) u_settle (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .load       (code_chg),
    .settle_len (settle_len),
    .hold       (hold)
  );

  clkcal_seq #(
    .LOCK_N (LOCK_N)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .cal_start (cal_start),
    .verdict   (verdict),
    .phase     (phase),
    .locked    (locked)
  );

  assign force_wc = (phase == PH_START);

  a_r2_idle_frozen: assert property (@(posedge clk) disable iff (!rst_int_n)
    (phase == PH_IDLE) |=> $stable(freq_code));

  a_r9_hold_frozen: assert property (@(posedge clk) disable iff (!rst_int_n)
    hold |=> $stable(freq_code));

  a_r10_no_vector: assert property (@(posedge clk) disable iff (!rst_int_n)
    !wc_seen |=> $stable(freq_code));

  a_r11_no_force_when_locked: assert property (@(posedge clk) disable iff (!rst_int_n)
    !(locked && force_wc));

endmodule

// File: tb/clkcal_ctrl_test.sv
module clkcal_ctrl_test;

  logic       clk;
  logic       rst_n;
  logic       cal_start, wc_seen, chk_late, chk_early;
  logic [3:0] settle_len;
  logic [7:0] freq_code;
  logic       hold, force_wc, locked;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  // bench model state
  int m_code, m_hold, m_phase, m_run;
  bit m_lock;

  clkcal_ctrl uut (
    .clk(clk), .rst_n(rst_n), .cal_start(cal_start), .wc_seen(wc_seen),
    .chk_late(chk_late), .chk_early(chk_early), .settle_len(settle_len),
    .freq_code(freq_code), .hold(hold), .force_wc(force_wc), .locked(locked)
  );

  initial clk = 0;
  always #10 clk = ~clk;

  task automatic check(input string tag, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic check_all(input string tag);
    check(tag, "freq_code", int'(freq_code), m_code);
    check(tag, "hold",      int'(hold),      (m_hold != 0) ? 1 : 0);
    check(tag, "force_wc",  int'(force_wc),  (m_phase == 1) ? 1 : 0);
    check(tag, "locked",    int'(locked),    int'(m_lock));
  endtask

  task automatic model_step(input bit cs, input bit wc, input bit lt, input bit er, input int sl);
    bit acc, chg, stop;
    int nh;
    acc  = (m_phase != 0) && wc && (m_hold == 0) && !cs;
    chg  = 0;
    stop = 0;
    if (acc) begin
      if (lt) begin
        if (m_code > 0) begin m_code--; chg = 1; end
      end else if (er) begin
        if (m_code < 255) begin m_code++; chg = 1; end
      end else stop = 1;
    end
    nh = chg ? sl : ((m_hold > 0) ? m_hold - 1 : 0);
    m_hold = nh;
    if (cs) begin
      m_phase = 1; m_run = 0; m_lock = 0;
    end else if (m_phase == 1 && acc) begin
      if (stop) begin
        if (m_run == 3) begin m_phase = 2; m_lock = 1; m_run = 0; end
        else m_run++;
      end else m_run = 0;
    end
  endtask

  // called at a falling edge: drive, advance one cycle, compare at next falling edge
  task automatic cyc(input bit cs, input bit wc, input bit lt, input bit er,
                     input int sl, input string tag);
    cal_start = cs; wc_seen = wc; chk_late = lt; chk_early = er;
    settle_len = 4'(sl);
    model_step(cs, wc, lt, er, sl);
    @(posedge clk);
    @(negedge clk);
    check_all(tag);
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240517));
    rst_n = 0; cal_start = 0; wc_seen = 0; chk_late = 0; chk_early = 0; settle_len = 0;
    m_code = 128; m_hold = 0; m_phase = 0; m_run = 0; m_lock = 0;
    repeat (3) @(negedge clk);
    check_all("R1 in reset");
    rst_n = 1;
    repeat (3) @(negedge clk);
    check_all("R1 after release");

    // R2: idle ignores results
    cyc(0, 1, 1, 0, 0, "R2 idle late");
    cyc(0, 1, 0, 1, 0, "R2 idle early");

    // R3: start request, same-cycle result ignored
    cyc(1, 1, 1, 0, 0, "R3 start");

    // R10: no worst-case vector
    cyc(0, 0, 1, 0, 0, "R10 no vector late");
    cyc(0, 0, 0, 1, 0, "R10 no vector early");

    // R4: late with priority over early; settle 0 gives no hold (R8)
    cyc(0, 1, 1, 1, 0, "R4 late wins");
    cyc(0, 1, 1, 0, 0, "R4 late");
    // R5
    cyc(0, 1, 0, 1, 0, "R5 early");
    // R6
    cyc(0, 1, 0, 0, 0, "R6 stop");
    cyc(0, 1, 0, 1, 0, "R6 run broken by step");

    // R8 and R9: hold of 3 cycles, results ignored during it
    cyc(0, 1, 1, 0, 3, "R8 change loads hold");
    cyc(0, 1, 1, 0, 3, "R9 hold ignores late");
    cyc(0, 1, 0, 1, 3, "R9 hold ignores early");
    cyc(0, 1, 0, 0, 3, "R9 hold ignores stop");
    cyc(0, 0, 0, 0, 3, "R8 hold ends");

    // R11: interrupted run, then full run of stops
    cyc(0, 1, 0, 0, 0, "R11 stop 1");
    cyc(0, 1, 0, 0, 0, "R11 stop 2");
    cyc(0, 1, 0, 1, 0, "R11 step restarts");
    for (int i = 0; i < 3; i++) cyc(0, 1, 0, 0, 0, "R11 stop run");
    cyc(0, 0, 0, 0, 0, "R11 gap not counted");
    cyc(0, 1, 0, 0, 0, "R11 final stop locks");

    // R12: in-situ steps after lock
    cyc(0, 1, 1, 0, 2, "R12 in situ down");
    cyc(0, 0, 0, 0, 2, "R12 holding");
    cyc(0, 0, 0, 0, 2, "R12 hold done");
    cyc(0, 1, 0, 1, 0, "R12 in situ up");

    // R7: saturate high and low
    cyc(1, 0, 0, 0, 0, "R3 restart");
    for (int i = 0; i < 130; i++) cyc(0, 1, 0, 1, 0, "R7 climb");
    cyc(0, 1, 0, 1, 5, "R7 top no wrap no hold");
    for (int i = 0; i < 258; i++) cyc(0, 1, 1, 0, 0, "R7 descend");
    cyc(0, 1, 1, 0, 5, "R7 bottom no wrap no hold");
    for (int i = 0; i < 4; i++) cyc(0, 1, 0, 0, 0, "R11 lock at bottom");

    // random mix
    for (int i = 0; i < 4000; i++) begin
      bit cs, wc, lt, er;
      int sl;
      cs = ($urandom_range(0, 199) == 0);
      wc = ($urandom_range(0, 1) == 1);
      lt = ($urandom_range(0, 3) == 0);
      er = ($urandom_range(0, 3) == 0);
      sl = $urandom_range(0, 3);
      cyc(cs, wc, lt, er, sl, "R12 random");
    end

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule